// File: doc/BRIEF.md
# Serial-Loaded Eight-Channel Converter Code Register Front End

This block is the digital front end of an eight-channel digital-to-analog converter. A host writes it over a three-wire serial port made of a shift clock, a serial data line and a load strobe. While the strobe is high, each rising edge of the shift clock moves one bit into an 18-bit frame register. The bit pushed out of the top of that register appears on a serial output, so several devices can be chained. The frame holds a 4-bit channel address in its upper bits and a 14-bit code below it. The address is sent first, most significant bit first.

When the strobe falls, the address is decoded and the code is written into one of eight holding registers. These registers drive the converters. Addresses that select no channel do nothing. While the strobe is low, the shift clock and data line are ignored, the frame register is frozen and the serial output enable is low. The codes are offset binary, so 0x2000 is the zero-volt output. An asynchronous active-low reset puts every channel at that code and clears the frame register.

All three serial pins are resynchronised into the system clock domain through the same number of stages, so they stay aligned with each other. Edges of the shift clock and of the strobe are detected in that domain. The strobe's falling edge gives a one-cycle load pulse.

Top module: `dacSerialIf`

## Requirements
- R1: While rstN is low, and as soon as it falls (without waiting for a clock edge), every channel code is 0x2000 and sdoEn is 0. The frame register is also cleared.
- R2: The frame is the last 18 bits shifted in, first bit highest. Frame bits 17..14 are the address and bits 13..0 are the code.
- R3: A falling edge of loadStrobe writes the frame code into channel N-1 when the address N lies in 1..8 (address 1 = channel 0, address 8 = channel 7).
- R4: Addresses 0 and 9 through 15 leave every channel unchanged when loadStrobe falls.
- R5: A load changes at most the one addressed channel; all other channels keep their codes.
- R6: While loadStrobe is low, serClk and serData have no effect: the frame register and sdo hold, and no channel changes.
- R7: sdoEn follows loadStrobe after the synchroniser delay. While it is high, sdo shows frame bit 17, which is the bit that leaves on the next shift.
- R8: Frames shorter or longer than 18 bits are not flagged. The load uses whatever the last 18 shifted bits are, so a short frame keeps the older low-order bits, moved upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock, sampled in the clk domain |
| serData | input | 1 | Serial data in, first bit = address MSB |
| loadStrobe | input | 1 | High: shift enabled; falling edge: load selected channel |
| chCode | output | 112 | Eight 14-bit offset-binary codes, channel k at bits 14k+13..14k |
| sdo | output | 1 | Serial data out (frame bit 17) |
| sdoEn | output | 1 | Output enable for sdo; low means high-impedance |

## Verification
The assertions assume that serClk, serData and loadStrobe change slowly compared with clk. Each level must be held for several system clocks, so that the synchronised copies show clean single edges. They also assume that loadStrobe does not fall in the same synchronised cycle as a shift-clock edge.

The stimulus keeps to these assumptions. It holds every serial level for three system clocks, and it raises or lowers the strobe only while serClk is low and has been stable for several cycles.

Frame contents, channel codes and the expected serial output sequence come from a bench model of the shift register and the channel table.

// File: rtl/dacSerialPkg.sv
package dacSerialPkg;

  // Strobes from the control unit to the datapath, one system cycle wide.
  typedef struct packed {
    logic shiftEn;  // move one serial bit into the frame register
    logic loadEn;   // commit the frame to the addressed channel
  } dacStrobes_t;

endpackage

// File: rtl/dacInputSync.sv
module dacInputSync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/dacCtrl.sv
module dacCtrl
  import dacSerialPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ldSync,
  input  logic        sclkSync,
  output dacStrobes_t strobes,
  output logic        sdoEn
);

  logic ldPrev;
  logic sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldPrev   <= 1'b0;
      sclkPrev <= 1'b0;
    end else begin
      ldPrev   <= ldSync;
      sclkPrev <= sclkSync;
    end
  end

  // A shift needs a rising shift clock while the strobe is high; a load needs
  // the strobe to go from high to low.
  always_comb begin
    strobes.shiftEn = sclkSync & ~sclkPrev & ldSync;
    strobes.loadEn  = ldPrev & ~ldSync;
  end

  assign sdoEn = ldSync;

endmodule

// File: rtl/dacDatapath.sv
module dacDatapath
  import dacSerialPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 14,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dacStrobes_t              strobes,
  input  logic                     sdiSync,
  output logic [NUM_CH*DATA_W-1:0] chCode,
  output logic                     sdo
);

  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [FRAME_W-1:0] frameReg;
  logic [ADDR_W-1:0]  frameAddr;
  logic [DATA_W-1:0]  frameData;
  logic [NUM_CH-1:0]  chSel;

  // Frame register: first bit in ends up at the top after FRAME_W shifts.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
    end else if (strobes.shiftEn) begin
      frameReg <= {frameReg[FRAME_W-2:0], sdiSync};
    end
  end

  assign frameAddr = frameReg[FRAME_W-1 -: ADDR_W];
  assign frameData = frameReg[DATA_W-1:0];
  assign sdo       = frameReg[FRAME_W-1];

  // One holding register per channel; address k+1 selects channel k.
  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(g + 1);
    logic [DATA_W-1:0] chReg;

    assign chSel[g] = (frameAddr == CH_ADDR);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chReg <= MID_CODE;
      end else if (strobes.loadEn && chSel[g]) begin
        chReg <= frameData;
      end
    end

    assign chCode[g*DATA_W +: DATA_W] = chReg;
  end

endmodule

// File: rtl/dacSerialIf.sv
module dacSerialIf
  import dacSerialPkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int DATA_W      = 14,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serClk,
  input  logic                     serData,
  input  logic                     loadStrobe,
  output logic [NUM_CH*DATA_W-1:0] chCode,
  output logic                     sdo,
  output logic                     sdoEn
);

  logic [2:0]  rawPins;
  logic [2:0]  syncPins;
  dacStrobes_t strobes;

  assign rawPins = {loadStrobe, serClk, serData};

  dacInputSync #(
    .WIDTH (3),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rawPins),
    .dout(syncPins)
  );

  dacCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ldSync  (syncPins[2]),
    .sclkSync(syncPins[1]),
    .strobes (strobes),
    .sdoEn   (sdoEn)
  );

  dacDatapath #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .sdiSync(syncPins[0]),
    .chCode (chCode),
    .sdo    (sdo)
  );

endmodule

// File: rtl/dacSerialIfChk.sv
module dacSerialIfChk
  import dacSerialPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 14
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_CH*DATA_W-1:0] chCode,
  input logic                     sdo,
  input logic                     sdoEn,
  input dacStrobes_t              strobes
);

  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [NUM_CH*DATA_W-1:0] prevCode;
  logic                     prevValid;
  logic [NUM_CH-1:0]        changedVec;
  logic                     allMid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevValid <= 1'b0;
    else       prevValid <= 1'b1;
  end

  always_ff @(posedge clk) prevCode <= chCode;

  always_comb begin
    allMid = 1'b1;
    for (int i = 0; i < NUM_CH; i++) begin
      changedVec[i] = prevCode[i*DATA_W +: DATA_W] != chCode[i*DATA_W +: DATA_W];
      if (chCode[i*DATA_W +: DATA_W] != MID_CODE) allMid = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_MID: assert (allMid && !sdoEn); // R1
    end
  end

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rstN)
    prevValid |-> $countones(changedVec) <= 1); // R5

  AST_WRITE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && changedVec != '0) |-> $past(strobes.loadEn)); // R3

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEn |=> !strobes.loadEn); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && !sdoEn && !$past(sdoEn)) |-> $stable(sdo)); // R6

  AST_SDO_SHIFT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (prevValid && sdoEn && $past(sdoEn) && !$past(strobes.shiftEn)) |-> $stable(sdo)); // R7

endmodule

bind dacSerialIf dacSerialIfChk #(
  .NUM_CH(NUM_CH),
  .DATA_W(DATA_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .chCode (chCode),
  .sdo    (sdo),
  .sdoEn  (sdoEn),
  .strobes(strobes)
);

// File: tb/dacSerialIf_tb.sv
module dacSerialIf_tb;

  localparam int NCH = 8;
  localparam int DW  = 14;
  localparam int FW  = 18;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic loadStrobe = 1'b0;
  logic [NCH*DW-1:0] chCode;
  logic sdo;
  logic sdoEn;

  int testsRun = 0;
  int testsFailed = 0;

  logic [FW-1:0] modelFrame;
  logic [DW-1:0] modelCh [NCH];

  always #10 clk = ~clk;

  dacSerialIf u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .loadStrobe(loadStrobe), .chCode(chCode), .sdo(sdo), .sdoEn(sdoEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    modelFrame = '0;
    for (int i = 0; i < NCH; i++) modelCh[i] = 14'h2000;
  endtask

  task automatic checkChannels(input string tag);
    for (int i = 0; i < NCH; i++)
      chk(tag, 32'(chCode[i*DW +: DW]), 32'(modelCh[i]));
  endtask

  // One serial bit; optionally checks sdo just before the shift edge.
  task automatic sendBit(input logic b, input logic checkSdo);
    @(negedge clk);
    serData = b;
    serClk  = 1'b0;
    repeat (3) @(negedge clk);
    if (checkSdo) chk("R7 sdo shows next outgoing bit", 32'(sdo), 32'(modelFrame[FW-1]));
    serClk = 1'b1;
    repeat (3) @(negedge clk);
    serClk = 1'b0;
    if (loadStrobe) modelFrame = {modelFrame[FW-2:0], b};
  endtask

  task automatic raiseLd();
    @(negedge clk);
    loadStrobe = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic dropLd();
    @(negedge clk);
    loadStrobe = 1'b0;
    repeat (6) @(negedge clk);
    if (modelFrame[17:14] >= 4'd1 && modelFrame[17:14] <= 4'd8)
      modelCh[modelFrame[17:14] - 4'd1] = modelFrame[13:0];
  endtask

  task automatic sendBits(input logic [31:0] bits, input int n, input logic checkSdo);
    for (int i = n - 1; i >= 0; i--) sendBit(bits[i], checkSdo);
  endtask

  task automatic writeFrame(input logic [3:0] addr, input logic [13:0] data);
    raiseLd();
    sendBits(32'({addr, data}), FW, 1'b0);
    dropLd();
  endtask

  task automatic doReset();
    @(negedge clk);
    loadStrobe = 1'b0;
    serClk = 1'b0;
    #3 rstN = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    checkChannels("R1 reset mid-scale code");
    chk("R1 sdoEn low after reset", 32'(sdoEn), 32'd0);
  endtask

  task automatic testEachChannel();
    for (int c = 0; c < NCH; c++) begin
      writeFrame(4'(c + 1), 14'(14'h0155 * (c + 3) + c));
      checkChannels("R3 R5 addressed channel write");
    end
    writeFrame(4'd8, 14'h3FFF);
    chk("R2 top channel full code", 32'(chCode[7*DW +: DW]), 32'h3FFF);
    writeFrame(4'd1, 14'h0000);
    chk("R2 channel 0 zero code", 32'(chCode[0 +: DW]), 32'h0000);
  endtask

  task automatic testNoOpAddr();
    writeFrame(4'd0, 14'h1234);
    checkChannels("R4 address 0 no-op");
    for (int a = 9; a < 16; a++) begin
      writeFrame(4'(a), 14'h2AAA);
      checkChannels("R4 unused address no-op");
    end
  endtask

  task automatic testIdleAndSdo();
    logic [FW-1:0] heldFrame;
    writeFrame(4'd3, 14'h0ABC);
    heldFrame = modelFrame;
    chk("R7 sdoEn low while strobe low", 32'(sdoEn), 32'd0);
    for (int i = 0; i < 10; i++) sendBit(1'(~i[0]), 1'b0);
    checkChannels("R6 idle shifting changes no channel");
    chk("R6 frame unchanged (model)", 32'(modelFrame), 32'(heldFrame));
    raiseLd();
    chk("R7 sdoEn high with strobe", 32'(sdoEn), 32'd1);
    chk("R6 sdo holds old frame top bit", 32'(sdo), 32'(heldFrame[FW-1]));
    sendBits(32'({4'd6, 14'h1F0F}), FW, 1'b1);
    dropLd();
    chk("R7 sdoEn drops after strobe", 32'(sdoEn), 32'd0);
    checkChannels("R3 load after streamed frame");
  endtask

  task automatic testShortLong();
    raiseLd();
    sendBits(32'h3, 4, 1'b0);
    sendBits(32'({4'd5, 14'h0777}), FW, 1'b0);
    dropLd();
    checkChannels("R8 long frame uses last 18 bits");
    chk("R8 long frame channel 4", 32'(chCode[4*DW +: DW]), 32'h0777);
    raiseLd();
    sendBits(32'h15, 7, 1'b0);
    dropLd();
    checkChannels("R8 short frame mixes older bits");
  endtask

  task automatic testAsyncReset();
    writeFrame(4'd2, 14'h0101);
    @(negedge clk);
    #4 rstN = 1'b0;
    #2;
    modelReset();
    checkChannels("R1 asynchronous reset before clock");
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    raiseLd();
    chk("R1 frame cleared, sdo zero", 32'(sdo), 32'd0);
    dropLd();
    checkChannels("R1 empty frame is no-op");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    modelReset();
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testEachChannel();
    testNoOpAddr();
    testIdleAndSdo();
    testShortLong();
    testAsyncReset();
    doReset();
    testReset();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule